// File: doc/BRIEF.md
# Flow-Control Pause Frame Injector

This block sits in front of a byte-wide transmit path, before the stage that adds the CRC and preamble. It normally forwards an ordinary data-frame source. When software writes a pause request, it builds a MAC control frame with the pause opcode and sends it on the same path. The frame carries the reserved multicast destination, the station's own address and the requested pause time, and is zero-filled to 60 bytes. The downstream stage appends the 4-byte CRC, so the frame is 64 bytes on the wire.

The two frame sources are arbitrated only between frames. A data frame that has started always runs to its end, and a pause frame that is waiting goes out at the next frame boundary. When both are waiting at a boundary, the pause frame goes first. A request takes effect only while flow control is enabled. The last pause time written before the frame starts is the one sent. Two sticky completion flags, one for each frame kind, drive a single interrupt line. Each flag is cleared by a pulse on its own clear input.

Top module: `pause_frame_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_valid`, `ctl_sent`, `dat_sent` and `irq` are all 0.
- R2: A pause frame is exactly 60 accepted bytes. Bytes 0 to 5 are 01 80 C2 00 00 01. `tx_sof` is high only on byte 0 and `tx_eof` only on byte 59.
- R3: Bytes 6 to 11 carry the station address in this order: `mac_hi[15:8]`, `mac_hi[7:0]`, `mac_lo[31:24]`, `mac_lo[23:16]`, `mac_lo[15:8]`, `mac_lo[7:0]`.
- R4: Bytes 12 to 15 are 88 08 00 01. Byte 16 is `quanta[15:8]` and byte 17 is `quanta[7:0]`. Bytes 18 to 59 are 00.
- R5: A request made while `flow_en` is 0 is held and sends nothing. It goes out once `flow_en` becomes 1.
- R6: A second request written before the frame starts replaces the pause time, so one frame carries the last value. A request is consumed when its first byte is accepted, so each request yields exactly one frame.
- R7: A request raised while a data frame is in progress waits. The data frame completes intact and the pause frame follows it directly.
- R8: When a pending enabled request and a waiting data frame meet at an idle boundary, the pause frame is sent first and the data frame follows.
- R9: A frame is never interrupted. While `tx_ready` is 0 the offered pause byte is held, and every byte of both frames arrives intact and in order under back-pressure.
- R10: Accepting the last pause byte sets `ctl_sent`. Accepting the last data byte sets `dat_sent`. `irq` is the OR of the two flags. A clear pulse resets its own flag, so `irq` drops only once both flags are clear.
- R11: A request written after a pause frame's first byte has been accepted produces a second pause frame. That frame carries the new value and directly follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_en | input | 1 | Transmit flow control enable |
| mac_hi | input | 16 | First two octets of the station address |
| mac_lo | input | 32 | Last four octets of the station address |
| ctl_wr | input | 1 | Write strobe for the transmit-control word |
| ctl_req | input | 1 | Request bit of the written word |
| ctl_quanta | input | 16 | Pause time of the written word |
| dat_valid | input | 1 | Data source has a byte |
| dat_byte | input | 8 | Data source byte |
| dat_last | input | 1 | Data source byte ends its frame |
| dat_ack | output | 1 | Data source byte taken this cycle |
| tx_ready | input | 1 | Downstream accepts a byte this cycle |
| tx_valid | output | 1 | Byte offered downstream |
| tx_byte | output | 8 | Offered byte |
| tx_sof | output | 1 | Offered byte starts a frame |
| tx_eof | output | 1 | Offered byte ends a frame |
| clr_ctl | input | 1 | Clear pulse for `ctl_sent` |
| clr_dat | input | 1 | Clear pulse for `dat_sent` |
| ctl_sent | output | 1 | Pause frame completed flag |
| dat_sent | output | 1 | Data frame completed flag |
| irq | output | 1 | Interrupt, OR of the two flags |

## Verification
The byte path is combinational from the registered arbitration state. A byte counts as accepted at the rising edge where `tx_valid` and `tx_ready` are both high. The bench records each such byte at the falling edge before that rising edge. All of its inputs change only at rising edges, so that record cannot race. A request strobe sampled at one edge can put the first pause byte on the outputs in the cycle right after it. Flags change on the edge that accepts a frame's last byte and are checked two falling edges later. A flag clear takes effect on the edge that samples the clear pulse and is checked at the next falling edge.

// File: rtl/pause_frame_tx.sv
module pause_frame_tx #(
  parameter int FRAME_LEN = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flow_en,
  input  logic [15:0] mac_hi,
  input  logic [31:0] mac_lo,
  input  logic        ctl_wr,
  input  logic        ctl_req,
  input  logic [15:0] ctl_quanta,
  input  logic        dat_valid,
  input  logic [7:0]  dat_byte,
  input  logic        dat_last,
  output logic        dat_ack,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_sof,
  output logic        tx_eof,
  input  logic        clr_ctl,
  input  logic        clr_dat,
  output logic        ctl_sent,
  output logic        dat_sent,
  output logic        irq
);

  localparam int LAST = FRAME_LEN - 1;
  localparam int IW   = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {S_IDLE, S_CTL, S_DAT} src_t;

  src_t          state, sel;
  logic [IW-1:0] idx;
  logic          pend, dat_mid;
  logic [15:0]   pend_q, send_q;
  logic [7:0]    cbyte;

  wire ctl_go   = pend & flow_en;
  wire ctl_last = (32'(idx) == LAST);

  always_comb begin
    sel = state;
    if (state == S_IDLE)
      sel = ctl_go ? S_CTL : (dat_valid ? S_DAT : S_IDLE);
  end

  wire in_ctl   = (sel == S_CTL);
  wire in_dat   = (sel == S_DAT);
  wire ctl_take = in_ctl & tx_ready;
  wire dat_take = in_dat & dat_valid & tx_ready;
  wire req_wr   = ctl_wr & ctl_req;

  always_comb begin
    cbyte = 8'h00;
    case (32'(idx))
      0:  cbyte = 8'h01;
      1:  cbyte = 8'h80;
      2:  cbyte = 8'hC2;
      5:  cbyte = 8'h01;
      6:  cbyte = mac_hi[15:8];
      7:  cbyte = mac_hi[7:0];
      8:  cbyte = mac_lo[31:24];
      9:  cbyte = mac_lo[23:16];
      10: cbyte = mac_lo[15:8];
      11: cbyte = mac_lo[7:0];
      12: cbyte = 8'h88;
      13: cbyte = 8'h08;
      15: cbyte = 8'h01;
      16: cbyte = send_q[15:8];
      17: cbyte = send_q[7:0];
      default: cbyte = 8'h00;
    endcase
  end

  assign tx_valid = in_ctl | (in_dat & dat_valid);
  assign tx_byte  = in_ctl ? cbyte : dat_byte;
  assign tx_sof   = in_ctl ? (idx == '0) : (in_dat & dat_valid & ~dat_mid);
  assign tx_eof   = in_ctl ? ctl_last : (in_dat & dat_valid & dat_last);
  assign dat_ack  = dat_take;
  assign irq      = ctl_sent | dat_sent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      dat_mid <= 1'b0;
    end else begin
      state <= sel;
      if (ctl_take) begin
        if (ctl_last) begin
          idx   <= '0;
          state <= S_IDLE;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (dat_take) begin
        dat_mid <= ~dat_last;
        if (dat_last) state <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      pend_q <= '0;
      send_q <= '0;
    end else begin
      if (ctl_take && idx == '0) begin
        send_q <= pend_q;
        pend   <= 1'b0;
      end
      if (req_wr) begin
        pend   <= 1'b1;
        pend_q <= ctl_quanta;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_sent <= 1'b0;
      dat_sent <= 1'b0;
    end else begin
      ctl_sent <= (ctl_sent & ~clr_ctl) | (ctl_take & ctl_last);
      dat_sent <= (dat_sent & ~clr_dat) | (dat_take & dat_last);
    end
  end

  AST_FIRST_BYTE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctl && tx_sof) |-> (tx_byte == 8'h01)); // R2
  AST_NO_TX_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !flow_en && !dat_valid) |-> !tx_valid); // R5
  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_take && tx_sof && !req_wr) |=> !pend); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ctl && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R9
  AST_DATA_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_take && !dat_last) |=> (sel == S_DAT)); // R7
  AST_CTL_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_take && tx_eof) |=> ctl_sent); // R10
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ctl && clr_dat && !(tx_valid && tx_ready && tx_eof)) |=> !irq); // R10

endmodule

// File: tb/sim_pause_frame_tx.sv
`timescale 1ns/1ps
module sim_pause_frame_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        flow_en = 1'b0, ctl_wr = 1'b0, ctl_req = 1'b0;
  logic [15:0] mac_hi = 16'h0001, ctl_q = 16'h0;
  logic [31:0] mac_lo = 32'h02030405;
  logic        clr_ctl = 1'b0, clr_dat = 1'b0, tx_ready = 1'b1, thr = 1'b0;
  logic        dat_ack, tx_valid, tx_sof, tx_eof, ctl_sent, dat_sent, irq;
  logic [7:0]  tx_byte;

  int          d_len = 1, d_cnt = 0;
  logic [7:0]  d_seed = 8'h0;
  logic        d_start = 1'b0, d_busy = 1'b0;
  wire         dat_valid = d_busy;
  wire  [7:0]  dat_byte = d_seed + 8'(d_cnt);
  wire         dat_last = (d_cnt == d_len - 1);
  logic [7:0]  lf = 8'h5B;

  int vecs = 0, mis = 0, cap_n = 0;
  bit done = 1'b0;
  logic [7:0] cap_b [0:4095];
  logic       cap_s [0:4095];
  logic       cap_e [0:4095];

  pause_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .mac_hi(mac_hi), .mac_lo(mac_lo),
    .ctl_wr(ctl_wr), .ctl_req(ctl_req), .ctl_quanta(ctl_q),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last), .dat_ack(dat_ack),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .clr_ctl(clr_ctl), .clr_dat(clr_dat),
    .ctl_sent(ctl_sent), .dat_sent(dat_sent), .irq(irq));

  always @(posedge clk) begin
    if (!rst_n) begin
      d_busy <= 1'b0; d_cnt <= 0;
    end else if (d_start) begin
      d_busy <= 1'b1; d_cnt <= 0;
    end else if (dat_ack) begin
      if (d_cnt == d_len - 1) d_busy <= 1'b0;
      d_cnt <= d_cnt + 1;
    end
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready <= thr ? lf[0] : 1'b1;
  end

  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready && cap_n < 4096) begin
      cap_b[cap_n] = tx_byte; cap_s[cap_n] = tx_sof; cap_e[cap_n] = tx_eof;
      cap_n = cap_n + 1;
    end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      mis++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctl(int k, logic [15:0] hi, logic [31:0] lo, logic [15:0] q);
    logic [7:0] h [0:17];
    h = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01, hi[15:8], hi[7:0],
          lo[31:24], lo[23:16], lo[15:8], lo[7:0], 8'h88, 8'h08, 8'h00, 8'h01, q[15:8], q[7:0]};
    return (k < 18) ? h[k] : 8'h00;
  endfunction

  task automatic chk_ctl(int base, logic [15:0] hi, logic [31:0] lo, logic [15:0] q);
    bit mk = 1'b1;
    for (int k = 0; k < 60; k++) begin
      string r;
      r = (k < 6) ? "R2 dest" : (k < 12) ? "R3 srcaddr" : (k < 18) ? "R4 type/op/quanta" : "R4 pad";
      chk(cap_b[base+k] === exp_ctl(k, hi, lo, q), r, 64'(cap_b[base+k]), 64'(exp_ctl(k, hi, lo, q)));
      if (cap_s[base+k] !== (k == 0) || cap_e[base+k] !== (k == 59)) mk = 1'b0;
    end
    chk(mk, "R2 sof/eof markers", 64'(base), 64'(base));
  endtask

  task automatic chk_dat(int base, int len, logic [7:0] seed, string r);
    bit mk = 1'b1;
    for (int k = 0; k < len; k++) begin
      chk(cap_b[base+k] === seed + 8'(k), r, 64'(cap_b[base+k]), 64'(seed + 8'(k)));
      if (cap_s[base+k] !== (k == 0) || cap_e[base+k] !== (k == len - 1)) mk = 1'b0;
    end
    chk(mk, {r, " data markers"}, 64'(base), 64'(base));
  endtask

  task automatic ctl_write(logic [15:0] q);
    @(posedge clk); ctl_wr <= 1'b1; ctl_req <= 1'b1; ctl_q <= q;
    @(posedge clk); ctl_wr <= 1'b0; ctl_req <= 1'b0;
  endtask

  task automatic dat_start(int len, logic [7:0] seed);
    @(posedge clk); d_len <= len; d_seed <= seed; d_start <= 1'b1;
    @(posedge clk); d_start <= 1'b0;
  endtask

  task automatic wait_cap(int n);
    while (cap_n < n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear(bit c, bit d);
    @(posedge clk); clr_ctl <= c; clr_dat <= d;
    @(posedge clk); clr_ctl <= 1'b0; clr_dat <= 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, mis);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mis++;
    $display("FAIL watchdog expired actual %0d expected %0d", cap_n, 0);
    finish_run();
  end

  initial begin
    int base;
    logic [15:0] qs [0:4];
    qs = '{16'h1111, 16'h2222, 16'h0000, 16'hFFFF, 16'hA55A};
    repeat (3) @(negedge clk);
    chk(!tx_valid && !irq && !ctl_sent && !dat_sent, "R1 in reset", {tx_valid, irq, ctl_sent, dat_sent}, 0);
    @(posedge clk); rst_n <= 1'b1;
    @(negedge clk);
    chk(!tx_valid && !irq && !ctl_sent && !dat_sent, "R1 after reset", {tx_valid, irq, ctl_sent, dat_sent}, 0);

    // R2 R3 R4 R6 R10: idle pause frames, sweep of pause times and addresses
    @(posedge clk); flow_en <= 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      mac_hi <= 16'h0001 + 16'(i) * 16'h1213;
      mac_lo <= 32'h02030405 ^ (32'(i) * 32'h11111111);
      base = cap_n;
      ctl_write(qs[i]);
      wait_cap(base + 60);
      chk_ctl(base, 16'h0001 + 16'(i) * 16'h1213, 32'h02030405 ^ (32'(i) * 32'h11111111), qs[i]);
      chk(ctl_sent && !dat_sent && irq, "R10 ctl flag", {ctl_sent, dat_sent, irq}, 3'b101);
      repeat (70) @(negedge clk);
      chk(cap_n == base + 60, "R6 one frame per request", 64'(cap_n - base), 60);
      clear(1'b1, 1'b0);
      chk(!ctl_sent && !irq, "R10 ctl clear", {ctl_sent, irq}, 0);
    end

    // R5 R6: gated request, replaced value
    @(posedge clk); flow_en <= 1'b0;
    base = cap_n;
    ctl_write(16'h1234);
    ctl_write(16'h4321);
    repeat (20) @(negedge clk);
    chk(cap_n == base && !tx_valid, "R5 gated no tx", 64'(cap_n - base), 0);
    @(posedge clk); flow_en <= 1'b1;
    wait_cap(base + 60);
    chk(cap_b[base+16] === 8'h43 && cap_b[base+17] === 8'h21, "R6 last value used",
        {cap_b[base+16], cap_b[base+17]}, 16'h4321);
    chk_ctl(base, mac_hi, mac_lo, 16'h4321);
    repeat (70) @(negedge clk);
    chk(cap_n == base + 60, "R6 replaced request single frame", 64'(cap_n - base), 60);
    clear(1'b1, 1'b1);

    // R7: request at many points inside a data frame
    for (int k = 1; k <= 16; k += 3) begin
      base = cap_n;
      dat_start(20, 8'h40 + 8'(k));
      while (cap_n < base + k) @(negedge clk);
      ctl_write(16'h1000 + 16'(k) * 16'h0101);
      wait_cap(base + 80);
      chk_dat(base, 20, 8'h40 + 8'(k), "R7 data first");
      chk_ctl(base + 20, mac_hi, mac_lo, 16'h1000 + 16'(k) * 16'h0101);
      chk(ctl_sent && dat_sent && irq, "R10 both flags", {ctl_sent, dat_sent, irq}, 3'b111);
      clear(1'b1, 1'b1);
      chk(!irq, "R10 both cleared", 64'(irq), 0);
    end

    // R8: pending request and data frame meet at idle
    @(posedge clk); flow_en <= 1'b0;
    base = cap_n;
    ctl_write(16'h3C3C);
    @(posedge clk); d_len <= 16; d_seed <= 8'hC0; d_start <= 1'b1;
    @(posedge clk); d_start <= 1'b0; flow_en <= 1'b1;
    wait_cap(base + 76);
    chk_ctl(base, mac_hi, mac_lo, 16'h3C3C);
    chk_dat(base + 60, 16, 8'hC0, "R8 data after ctl");
    clear(1'b1, 1'b1);

    // R9: back-pressure on both frame kinds
    @(posedge clk); thr <= 1'b1;
    base = cap_n;
    ctl_write(16'h7E81);
    dat_start(25, 8'h90);
    wait_cap(base + 85);
    chk_ctl(base, mac_hi, mac_lo, 16'h7E81);
    chk_dat(base + 60, 25, 8'h90, "R9 data under stall");
    @(posedge clk); thr <= 1'b0;

    // R10: separate clears, irq follows both flags
    @(negedge clk);
    chk(ctl_sent && dat_sent && irq, "R10 flags before clear", {ctl_sent, dat_sent, irq}, 3'b111);
    clear(1'b1, 1'b0);
    chk(!ctl_sent && dat_sent && irq, "R10 irq held by data flag", {ctl_sent, dat_sent, irq}, 3'b011);
    clear(1'b0, 1'b1);
    chk(!ctl_sent && !dat_sent && !irq, "R10 irq drops", {ctl_sent, dat_sent, irq}, 0);

    // R11: new request during a pause frame
    base = cap_n;
    ctl_write(16'h0102);
    while (cap_n < base + 10) @(negedge clk);
    ctl_write(16'h0304);
    wait_cap(base + 120);
    chk_ctl(base, mac_hi, mac_lo, 16'h0102);
    chk_ctl(base + 60, mac_hi, mac_lo, 16'h0304);
    repeat (70) @(negedge clk);
    chk(cap_n == base + 120, "R11 exactly two frames", 64'(cap_n - base), 120);

    finish_run();
  end
endmodule